// File: doc/BRIEF.md
# Flash Virtual Bank Address Remapper

This block sits on the path from a host local-bus address to a 128 MB parallel NOR flash. The host reaches the flash through a fixed 128 MB window at 0xE800_0000 to 0xEFFF_FFFF. That window is cut into eight 16 MB virtual banks, and the banks run opposite to address order. Bank 0 is the top 16 MB, starting at 0xEF00_0000. Bank 7 is the bottom 16 MB, starting at 0xE800_0000. In general bank k starts at 0xEF00_0000 minus k times 16 MB.

A 3-bit bank select comes from board configuration switches. The block XORs it into the bank field of every access that falls in the window. A boot image kept in any bank therefore answers at the addresses normally used by bank 0. Each boot image lives in the last 512 KB of its bank. Its block of configuration words sits at the start of bank 7−i. With select 0, which is the default, the flash address is the plain low 27 bits of the host address.

The select is captured only while reset is held, so the mapping cannot move under a running fetch. A build option keeps only the two-configuration variant, in which the only usable banks are 0 and 4.

Top module: `flash_bank_remap`

## Requirements
- R1: `win_hit` is 1 exactly when `cs` is 1 and `host_addr[31:27]` equals 5'b11101, i.e. the address lies in 0xE800_0000..0xEFFF_FFFF.
- R2: When `win_hit` is 0 (`cs` low or address outside the window), `flash_addr` is all zeros.
- R3: On a hit, `flash_addr[23:0]` equals `host_addr[23:0]`; the offset inside a 16 MB bank passes through unchanged.
- R4: On a hit, `flash_addr[26:24]` equals `host_addr[26:24]` XOR the latched bank select.
- R5: With latched select 0, a hit gives `flash_addr` equal to `host_addr[26:0]` (no remap).
- R6: With select s, the boot image of bank s (its last 512 KB) is reached at host 0xEFF8_0000..0xEFFF_FFFF. Example: with select 4, host 0xEBF8_0000 gives flash 0x7F8_0000, the same location that select 0 reaches through host 0xEFF8_0000.
- R7: With select i, host 0xE800_0000 (start of bank 7) reaches flash byte address i·16 MB, which is the start of bank 7−i. Example: select 4 gives 0x400_0000.
- R8: `bank_sel` is sampled on rising clock edges while `rst_n` is 0. Changes to it after reset has been released have no effect on `flash_addr`.
- R9: With `SEL_MODE` = SEL_TWO_CFG, only `bank_sel[2]` is honoured. A select of 3 behaves as 0, and a select of 6 behaves as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select capture register |
| rst_n | input | 1 | Active-low reset; the bank select is captured while it is low |
| host_addr | input | 32 | Host local-bus byte address |
| cs | input | 1 | Chip-select strobe, active high |
| bank_sel | input | 3 | Bank select from configuration switches |
| flash_addr | output | 27 | Flash byte address after bank remap, zero when there is no hit |
| win_hit | output | 1 | High when the access falls in the flash window with chip select active |

## Verification
The main function is driven from a vector table whose rows pair different latched selects (0, 1, 2, 3, 4, 5, 7) with addresses at bank starts, at boot-image starts, at the last word of the window, and at mid-bank offsets. Rows with select 0 show that the path passes the address through unchanged. Rows with other selects tell an XOR of the bank field apart from an add, a subtract or a bit reversal. Addresses just below and just above the window, and a row with chip select low, separate a correct window decode from a wrong tag compare or a missing strobe gate. Directed tests then change `bank_sel` after reset is released, and run a second instance built in two-configuration mode, to show that the mapping stays frozen and that the variant masks the select.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  // How much of the switch value is honoured.
  typedef enum logic {
    SEL_FULL    = 1'b0,
    SEL_TWO_CFG = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/fbr_sel_hold.sv
module fbr_sel_hold
  import fbr_pkg::*;
#(
  parameter int        BANK_W   = 3,
  parameter sel_mode_e SEL_MODE = SEL_FULL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] sel_raw,
  output logic [BANK_W-1:0] sel_q
);
  logic [BANK_W-1:0] sel_mask;

  generate
    if (SEL_MODE == SEL_TWO_CFG) begin : g_two_cfg
      // only the top select bit survives: bank 0 or bank 2**(BANK_W-1)
      assign sel_mask = {1'b1, {(BANK_W-1){1'b0}}};
    end else begin : g_full
      assign sel_mask = {BANK_W{1'b1}};
    end
  endgenerate

  // capture while reset is held, freeze afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= sel_raw & sel_mask;
  end

  // R8: the captured select never moves once reset has been released
  assert_sel_frozen_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(sel_q));

  // R9: masked bits of the select stay clear
  assert_sel_masked_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q & ~sel_mask) == '0);
endmodule

// File: rtl/fbr_win_decode.sv
module fbr_win_decode #(
  parameter int TAG_W = 5,
  parameter logic [TAG_W-1:0] WIN_TAG = 5'b11101
) (
  input  logic             cs,
  input  logic [TAG_W-1:0] addr_tag,
  output logic             hit
);
  function automatic logic tag_match(input logic [TAG_W-1:0] t);
    return t == WIN_TAG;
  endfunction

  assign hit = cs & tag_match(addr_tag);
endmodule

// File: rtl/fbr_bank_xlate.sv
module fbr_bank_xlate #(
  parameter int FLASH_AW = 27,
  parameter int BANK_W   = 3
) (
  input  logic                hit,
  input  logic [FLASH_AW-1:0] addr_in,
  input  logic [BANK_W-1:0]   sel,
  output logic [BANK_W-1:0]   bank_field_in,
  output logic [BANK_W-1:0]   bank_field_out,
  output logic [FLASH_AW-1:0] addr_out
);
  localparam int OFS_W = FLASH_AW - BANK_W;

  function automatic logic [BANK_W-1:0] fold_bank(input logic [BANK_W-1:0] f,
                                                   input logic [BANK_W-1:0] s);
    return f ^ s;
  endfunction

  assign bank_field_in  = addr_in[FLASH_AW-1:OFS_W];
  assign bank_field_out = fold_bank(bank_field_in, sel);
  assign addr_out = hit ? {bank_field_out, addr_in[OFS_W-1:0]} : '0;
endmodule

// File: rtl/flash_bank_remap.sv
module flash_bank_remap
  import fbr_pkg::*;
#(
  parameter int        ADDR_W   = 32,
  parameter int        FLASH_AW = 27,
  parameter int        BANK_W   = 3,
  parameter logic [ADDR_W-FLASH_AW-1:0] WIN_TAG = 5'b11101,
  parameter sel_mode_e SEL_MODE = SEL_FULL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                cs,
  input  logic [BANK_W-1:0]   bank_sel,
  output logic [FLASH_AW-1:0] flash_addr,
  output logic                win_hit
);
  localparam int TAG_W = ADDR_W - FLASH_AW;
  localparam int OFS_W = FLASH_AW - BANK_W;

  logic [BANK_W-1:0] sel_q;
  logic [BANK_W-1:0] bank_field_in;
  logic [BANK_W-1:0] bank_field_out;

  fbr_sel_hold #(.BANK_W(BANK_W), .SEL_MODE(SEL_MODE)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_raw (bank_sel),
    .sel_q   (sel_q)
  );

  fbr_win_decode #(.TAG_W(TAG_W), .WIN_TAG(WIN_TAG)) u_win (
    .cs       (cs),
    .addr_tag (host_addr[ADDR_W-1:FLASH_AW]),
    .hit      (win_hit)
  );

  fbr_bank_xlate #(.FLASH_AW(FLASH_AW), .BANK_W(BANK_W)) u_xlate (
    .hit            (win_hit),
    .addr_in        (host_addr[FLASH_AW-1:0]),
    .sel            (sel_q),
    .bank_field_in  (bank_field_in),
    .bank_field_out (bank_field_out),
    .addr_out       (flash_addr)
  );

  // R1: no hit without the strobe
  assert_hit_needs_cs_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> cs);

  // R2: a miss drives a quiet address
  assert_miss_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> flash_addr == '0);

  // R3: offset inside the bank is untouched
  assert_offset_pass_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> flash_addr[OFS_W-1:0] == host_addr[OFS_W-1:0]);

  // R4: undoing the fold with the held select gives back the host bank field
  assert_fold_inverts_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (flash_addr[FLASH_AW-1:OFS_W] ^ sel_q) == bank_field_in);

  // R5: select zero is the identity map
  assert_identity_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && sel_q == '0) |-> flash_addr == host_addr[FLASH_AW-1:0]);
endmodule

// File: tb/flash_bank_remap_test.sv
module flash_bank_remap_test;
  import fbr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] host_addr = '0;
  logic        cs = 1'b0;
  logic [2:0]  bank_sel = '0;
  logic [26:0] flash_addr, flash_addr_two;
  logic        win_hit, win_hit_two;

  int tests_run = 0;
  int tests_failed = 0;

  always #5 clk = ~clk;   // 100 MHz

  flash_bank_remap uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .cs(cs),
    .bank_sel(bank_sel), .flash_addr(flash_addr), .win_hit(win_hit)
  );

  flash_bank_remap #(.SEL_MODE(SEL_TWO_CFG)) uut_two (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .cs(cs),
    .bank_sel(bank_sel), .flash_addr(flash_addr_two), .win_hit(win_hit_two)
  );

  // {sel, cs, host address, expected hit, expected flash address, requirement}
  typedef struct packed {
    logic [2:0]  sel;
    logic        cs;
    logic [31:0] addr;
    logic        hit;
    logic [26:0] fa;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b1, 32'hEFF8_0000, 1'b1, 27'h7F8_0000, 4'd5}, // R5 bank 0 boot image
    '{3'd0, 1'b1, 32'hE800_0000, 1'b1, 27'h000_0000, 4'd5}, // R5 bank 7 start
    '{3'd4, 1'b1, 32'hEBF8_0000, 1'b1, 27'h7F8_0000, 4'd6}, // R6 bank 4 image
    '{3'd4, 1'b1, 32'hE800_0000, 1'b1, 27'h400_0000, 4'd7}, // R7 config words
    '{3'd4, 1'b1, 32'hEFFF_FFFC, 1'b1, 27'h3FF_FFFC, 4'd4}, // R4 last word
    '{3'd7, 1'b1, 32'hE812_3456, 1'b1, 27'h712_3456, 4'd3}, // R3 offset
    '{3'd3, 1'b1, 32'hED00_0010, 1'b1, 27'h600_0010, 4'd4}, // R4
    '{3'd0, 1'b0, 32'hEFF8_0000, 1'b0, 27'h000_0000, 4'd1}, // R1 cs low
    '{3'd0, 1'b1, 32'hF000_0000, 1'b0, 27'h000_0000, 4'd2}, // R2 above window
    '{3'd0, 1'b1, 32'hE7FF_FFFF, 1'b0, 27'h000_0000, 4'd2}, // R2 below window
    '{3'd5, 1'b1, 32'hEA55_AA55, 1'b1, 27'h755_AA55, 4'd4}, // R4
    '{3'd2, 1'b1, 32'hEFFF_FFFF, 1'b1, 27'h5FF_FFFF, 4'd6}, // R6
    '{3'd1, 1'b1, 32'h0000_0000, 1'b0, 27'h000_0000, 4'd1}  // R1 low address
  };

  task automatic check(input string tag, input logic [27:0] got, input logic [27:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got hit=%0b addr=%h, expected hit=%0b addr=%h",
               tag, got[27], got[26:0], exp[27], exp[26:0]);
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    bank_sel = s;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic c, input logic [31:0] a);
    @(negedge clk);
    cs = c;
    host_addr = a;
    #1;
  endtask

  initial begin
    #200000;
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    // reset state: select 6 captured, strobe idle gives a quiet output (R2)
    do_reset(3'd6);
    drive(1'b0, 32'hEF00_0000);
    check("R2 reset idle", {win_hit, flash_addr}, {1'b0, 27'h0});
    drive(1'b1, 32'hEF00_0000);
    check("R4 reset capture sel6", {win_hit, flash_addr}, {1'b1, 27'h100_0000});

    // R8: select moved after reset release has no effect
    @(negedge clk);
    bank_sel = 3'd0;
    repeat (3) @(posedge clk);
    drive(1'b1, 32'hEF00_0000);
    check("R8 select frozen", {win_hit, flash_addr}, {1'b1, 27'h100_0000});

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      do_reset(VECS[i].sel);
      drive(VECS[i].cs, VECS[i].addr);
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            {win_hit, flash_addr}, {VECS[i].hit, VECS[i].fa});
    end

    // R9: two-configuration build honours only the top select bit
    do_reset(3'd3);
    drive(1'b1, 32'hEFF8_0000);
    check("R9 sel3 acts as 0", {win_hit_two, flash_addr_two}, {1'b1, 27'h7F8_0000});
    do_reset(3'd6);
    drive(1'b1, 32'hEBF8_0000);
    check("R9 sel6 acts as 4", {win_hit_two, flash_addr_two}, {1'b1, 27'h7F8_0000});
    drive(1'b1, 32'hE800_0000);
    check("R9 R7 config words", {win_hit_two, flash_addr_two}, {1'b1, 27'h400_0000});

    // R1: window edges
    drive(1'b1, 32'hE800_0000);
    check("R1 lowest window byte", {win_hit, 27'h0}, {1'b1, 27'h0});
    drive(1'b0, 32'hE800_0000);
    check("R1 R2 strobe dropped", {win_hit, flash_addr}, {1'b0, 27'h0});

    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule